// File: doc/BRIEF.md
# Six-plane tile map renderer

This block produces a raster video stream from a character-cell tile map held in video RAM. A free-running pixel counter scans a frame of `H_TOTAL` clocks by `V_TOTAL` lines. Inside the active window, which is `COLS` by `ROWS` cells of 8x8 pixels, the block fetches a two-byte tile entry for each cell. It then reads one row byte from each of six graphics plane memories and shifts the bytes out as a 6-bit pixel code. The code is turned into 8-bit red, green and blue values by fixed weighted sums.

The block is a pure reader. It drives one synchronous video RAM read port and one shared read address for the six plane memories. Each of these memories returns its data on the clock after the address. The fetch for a cell runs one cell ahead of its display, and the sync and display-enable flags pass through a matching delay. Every output is therefore a fixed 9 clocks behind the scan counter that produced it.

Top module: `hexplane_tilemap`

## Requirements
- R1: A synchronous active-high reset clears the scan to pixel 0 of line 0 and forces all colour outputs, `de_o`, `hsync_o` and `vsync_o` low. Scan position (X, Y) appears on the outputs 9 clocks after the counter holds it, and the first clock after reset holds position (0, 0).
- R2: `de_o` is high exactly for X < COLS*8 and Y < ROWS*8. With the defaults this is a 304 by 216 window in a 384 by 256 frame.
- R3: The tile entry for cell (col, row) is the video RAM byte pair at addresses 2*(row*COLS+col) and 2*(row*COLS+col)+1. The byte at the even address is the high byte of the 16-bit entry.
- R4: Only entry bits TILE_BITS-1..0 (9 bits by default) select the tile. The upper entry bits have no effect on the picture.
- R5: The plane address is tile*8 + (Y mod 8). Bit 7 of each plane byte is the leftmost pixel of the cell, and bit 0 is the rightmost.
- R6: Plane data byte k sits at `plane_data[8k+7:8k]`. Pixel code bits 5,4,3,2,1,0 are taken from planes 3,0,4,1,5,2 respectively.
- R7: Blue = 0x4F·c0 + 0xA8·c1, where c is the pixel code.
- R8: Green = 0x21·c1 + 0x47·c2 + 0x97·c3 and red = 0x21·c3 + 0x47·c4 + 0x97·c5. Code bits 1 and 3 each feed two channels.
- R9: `hsync_o` is high for X from HS_BEGIN to HS_END inclusive (default 320..351) and never overlaps `de_o`.
- R10: `vsync_o` is high for lines VS_BEGIN to VS_END inclusive (default 230..233). It changes only at the start of an output line.
- R11: The latency from scan counter to outputs is the same for every pixel, sync and enable: 9 clocks.
- R12: Red, green and blue are zero whenever `de_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| vram_addr | output | VAW | Video RAM byte address (VAW = clog2(COLS*ROWS*2)) |
| vram_data | input | 8 | Video RAM byte, valid one clock after its address |
| rom_addr | output | TILE_BITS+3 | Shared plane memory address: tile and row in cell |
| plane_data | input | 48 | Six plane bytes, byte k at bits 8k+7..8k, valid one clock after the address |
| red_o | output | 8 | Red intensity |
| green_o | output | 8 | Green intensity |
| blue_o | output | 8 | Blue intensity |
| hsync_o | output | 1 | Line sync, active high |
| vsync_o | output | 1 | Frame sync, active high |
| de_o | output | 1 | Display enable |

## Verification
The bench builds the block with a 5 by 3 cell grid, a 56-clock line with sync at 44..47, and a 30-line frame with sync on lines 26..27. `TILE_BITS` keeps its default of 9. A whole frame then takes only 1680 clocks, so each reset phase covers two complete frames. Within that span the bench sees every line wrap, the frame wrap, both sync windows and the blanking after the last cell. The full 9-bit tile field is still exercised, including entries whose upper bits are set and tile codes near 0x1FF.

// File: rtl/hexplane_pkg.sv
package hexplane_pkg;
  localparam int CELL_PX  = 8;
  localparam int CELL_SH  = 3;
  localparam int NPLANES  = 6;
  localparam int PIPE_LAT = 9;

  localparam logic [7:0] WT_LO  = 8'h21;
  localparam logic [7:0] WT_MID = 8'h47;
  localparam logic [7:0] WT_HI  = 8'h97;
  localparam logic [7:0] WB_LO  = 8'h4F;
  localparam logic [7:0] WB_HI  = 8'hA8;

  typedef logic [NPLANES-1:0] pix_code_t;

  typedef struct packed {
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
  } rgb_t;

  // msb[k] is the current leftmost bit of plane k
  function automatic pix_code_t code_from_planes(input logic [NPLANES-1:0] msb);
    return {msb[3], msb[0], msb[4], msb[1], msb[5], msb[2]};
  endfunction

  function automatic logic [7:0] weigh3(input logic lo, input logic mid, input logic hi);
    return (lo ? WT_LO : 8'h00) + (mid ? WT_MID : 8'h00) + (hi ? WT_HI : 8'h00);
  endfunction

  function automatic rgb_t code_to_rgb(input pix_code_t c);
    rgb_t o;
    o.b = (c[0] ? WB_LO : 8'h00) + (c[1] ? WB_HI : 8'h00);
    o.g = weigh3(c[1], c[2], c[3]);
    o.r = weigh3(c[3], c[4], c[5]);
    return o;
  endfunction
endpackage

// File: rtl/hexplane_scan.sv
module hexplane_scan
  import hexplane_pkg::*;
#(
  parameter int H_TOTAL  = 384,
  parameter int V_TOTAL  = 256,
  parameter int ACT_W    = 304,
  parameter int ACT_H    = 216,
  parameter int HS_BEGIN = 320,
  parameter int HS_END   = 351,
  parameter int VS_BEGIN = 230,
  parameter int VS_END   = 233,
  parameter int HW       = $clog2(H_TOTAL),
  parameter int VW       = $clog2(V_TOTAL)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [HW-1:0] hpos,
  output logic [VW-1:0] vpos,
  output logic          de_pre,
  output logic          de_out,
  output logic          hs_out,
  output logic          vs_out
);
  localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL - 1);
  localparam logic [VW-1:0] V_LAST = VW'(V_TOTAL - 1);
  localparam logic [HW-1:0] ACT_W_C = HW'(ACT_W);
  localparam logic [VW-1:0] ACT_H_C = VW'(ACT_H);
  localparam logic [HW-1:0] HSB_C = HW'(HS_BEGIN);
  localparam logic [HW-1:0] HSE_C = HW'(HS_END);
  localparam logic [VW-1:0] VSB_C = VW'(VS_BEGIN);
  localparam logic [VW-1:0] VSE_C = VW'(VS_END);

  logic line_end, frame_end;
  logic de_now, hs_now, vs_now;
  logic [PIPE_LAT-1:0] de_p, hs_p, vs_p;

  assign line_end  = (hpos == H_LAST);
  assign frame_end = line_end && (vpos == V_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      hpos <= '0;
      vpos <= '0;
    end else if (line_end) begin
      hpos <= '0;
      vpos <= frame_end ? '0 : vpos + 1'b1;
    end else begin
      hpos <= hpos + 1'b1;
    end
  end

  assign de_now = (hpos < ACT_W_C) && (vpos < ACT_H_C);
  assign hs_now = (hpos >= HSB_C) && (hpos <= HSE_C);
  assign vs_now = (vpos >= VSB_C) && (vpos <= VSE_C);

  // flags follow the same number of stages as the pixel data path
  always_ff @(posedge clk) begin
    if (rst) begin
      de_p <= '0;
      hs_p <= '0;
      vs_p <= '0;
    end else begin
      de_p <= {de_p[PIPE_LAT-2:0], de_now};
      hs_p <= {hs_p[PIPE_LAT-2:0], hs_now};
      vs_p <= {vs_p[PIPE_LAT-2:0], vs_now};
    end
  end

  assign de_pre = de_p[PIPE_LAT-2];
  assign de_out = de_p[PIPE_LAT-1];
  assign hs_out = hs_p[PIPE_LAT-1];
  assign vs_out = vs_p[PIPE_LAT-1];
endmodule

// File: rtl/hexplane_fetch.sv
module hexplane_fetch
  import hexplane_pkg::*;
#(
  parameter int COLS      = 38,
  parameter int TILE_BITS = 9,
  parameter int HW        = 9,
  parameter int VW        = 8,
  parameter int VAW       = 12,
  parameter int RAW       = TILE_BITS + CELL_SH
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [HW-1:0]  hpos,
  input  logic [VW-1:0]  vpos,
  output logic [VAW-1:0] vram_addr,
  input  logic [7:0]     vram_data,
  output logic [RAW-1:0] rom_addr,
  output logic [15:0]    entry_w,
  output logic           cell_load
);
  logic [CELL_SH-1:0]    sub;
  logic [HW-CELL_SH-1:0] col;
  logic [VW-CELL_SH-1:0] trow;
  int                    entry_idx;
  logic [7:0]            hi_q;
  logic [TILE_BITS-1:0]  tile_q;
  logic                  entry_hi_unused;

  assign sub  = hpos[CELL_SH-1:0];
  assign col  = hpos[HW-1:CELL_SH];
  assign trow = vpos[VW-1:CELL_SH];

  always_comb entry_idx = int'(trow) * COLS + int'(col);

  // sub 0: high byte address, sub 1: low byte address
  assign vram_addr = VAW'(2 * entry_idx + ((sub == 3'd1) ? 1 : 0));

  assign entry_w = {hi_q, vram_data};
  assign entry_hi_unused = ^entry_w[15:TILE_BITS];

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q   <= '0;
      tile_q <= '0;
    end else begin
      if (sub == 3'd1) hi_q <= vram_data;
      if (sub == 3'd2) tile_q <= entry_w[TILE_BITS-1:0];
    end
  end

  assign rom_addr  = {tile_q, vpos[CELL_SH-1:0]};
  assign cell_load = (sub == 3'(CELL_PX - 1));
endmodule

// File: rtl/hexplane_shifter.sv
module hexplane_shifter
  import hexplane_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cell_load,
  input  logic [NPLANES*8-1:0]   plane_data,
  output pix_code_t              code
);
  logic [NPLANES-1:0] msb;

  for (genvar k = 0; k < NPLANES; k++) begin : g_plane
    logic [7:0] sr;
    always_ff @(posedge clk) begin
      if (rst)            sr <= '0;
      else if (cell_load) sr <= plane_data[k*8 +: 8];
      else                sr <= {sr[6:0], 1'b0};
    end
    assign msb[k] = sr[7];
  end

  assign code = code_from_planes(msb);
endmodule

// File: rtl/hexplane_colour.sv
module hexplane_colour
  import hexplane_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      de_pre,
  input  pix_code_t code,
  output rgb_t      rgb_q
);
  always_ff @(posedge clk) begin
    if (rst)         rgb_q <= '0;
    else if (de_pre) rgb_q <= code_to_rgb(code);
    else             rgb_q <= '0;
  end
endmodule

// File: rtl/hexplane_tilemap.sv
module hexplane_tilemap
  import hexplane_pkg::*;
#(
  parameter int COLS      = 38,
  parameter int ROWS      = 27,
  parameter int TILE_BITS = 9,
  parameter int H_TOTAL   = 384,
  parameter int HS_BEGIN  = 320,
  parameter int HS_END    = 351,
  parameter int V_TOTAL   = 256,
  parameter int VS_BEGIN  = 230,
  parameter int VS_END    = 233
) (
  input  logic                              clk,
  input  logic                              rst,
  output logic [$clog2(COLS*ROWS*2)-1:0]    vram_addr,
  input  logic [7:0]                        vram_data,
  output logic [TILE_BITS+CELL_SH-1:0]      rom_addr,
  input  logic [NPLANES*8-1:0]              plane_data,
  output logic [7:0]                        red_o,
  output logic [7:0]                        green_o,
  output logic [7:0]                        blue_o,
  output logic                              hsync_o,
  output logic                              vsync_o,
  output logic                              de_o
);
  localparam int ACT_W = COLS * CELL_PX;
  localparam int ACT_H = ROWS * CELL_PX;
  localparam int HW    = $clog2(H_TOTAL);
  localparam int VW    = $clog2(V_TOTAL);
  localparam int VAW   = $clog2(COLS*ROWS*2);
  localparam int RAW   = TILE_BITS + CELL_SH;

  logic [HW-1:0] hpos;
  logic [VW-1:0] vpos;
  logic          de_pre;
  logic [15:0]   entry_w;
  logic          cell_load;
  pix_code_t     code;
  rgb_t          rgb_q;

  hexplane_scan #(
    .H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL), .ACT_W(ACT_W), .ACT_H(ACT_H),
    .HS_BEGIN(HS_BEGIN), .HS_END(HS_END), .VS_BEGIN(VS_BEGIN), .VS_END(VS_END),
    .HW(HW), .VW(VW)
  ) u_scan (
    .clk(clk), .rst(rst), .hpos(hpos), .vpos(vpos),
    .de_pre(de_pre), .de_out(de_o), .hs_out(hsync_o), .vs_out(vsync_o)
  );

  hexplane_fetch #(
    .COLS(COLS), .TILE_BITS(TILE_BITS), .HW(HW), .VW(VW), .VAW(VAW), .RAW(RAW)
  ) u_fetch (
    .clk(clk), .rst(rst), .hpos(hpos), .vpos(vpos),
    .vram_addr(vram_addr), .vram_data(vram_data),
    .rom_addr(rom_addr), .entry_w(entry_w), .cell_load(cell_load)
  );

  hexplane_shifter u_shift (
    .clk(clk), .rst(rst), .cell_load(cell_load),
    .plane_data(plane_data), .code(code)
  );

  hexplane_colour u_colour (
    .clk(clk), .rst(rst), .de_pre(de_pre), .code(code), .rgb_q(rgb_q)
  );

  assign red_o   = rgb_q.r;
  assign green_o = rgb_q.g;
  assign blue_o  = rgb_q.b;
endmodule

// File: rtl/hexplane_tilemap_sva.sv
module hexplane_tilemap_sva
  import hexplane_pkg::*;
#(
  parameter int HW        = 9,
  parameter int VAW       = 12,
  parameter int RAW       = 12,
  parameter int TILE_BITS = 9
) (
  input logic                 clk,
  input logic                 rst,
  input logic [HW-1:0]        hpos,
  input logic [CELL_SH-1:0]   row_in_cell,
  input logic [VAW-1:0]       vram_addr,
  input logic [RAW-1:0]       rom_addr,
  input logic [TILE_BITS-1:0] tile_field,
  input logic                 de_o,
  input logic                 hs_o,
  input logic                 vs_o,
  input logic [7:0]           red,
  input logic [7:0]           green,
  input logic [7:0]           blue
);
  logic [CELL_SH-1:0] sub;
  assign sub = hpos[CELL_SH-1:0];

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!de_o && !hs_o && !vs_o && red == 8'h00 && green == 8'h00 && blue == 8'h00));

  assert_lo_byte_next_R3: assert property (@(posedge clk) disable iff (rst)
    (sub == 3'd1) |-> (vram_addr == VAW'($past(vram_addr) + 1'b1)));

  assert_tile_field_R4: assert property (@(posedge clk) disable iff (rst)
    (sub == 3'd3) |-> (rom_addr[RAW-1:CELL_SH] == $past(tile_field)));

  assert_plane_row_R5: assert property (@(posedge clk) disable iff (rst)
    (sub >= 3'd3) |-> (rom_addr[CELL_SH-1:0] == row_in_cell));

  assert_hsync_outside_R9: assert property (@(posedge clk) disable iff (rst)
    !(de_o && hs_o));

  assert_vsync_line_edge_R10: assert property (@(posedge clk) disable iff (rst)
    !$stable(vs_o) |-> (hpos == HW'(PIPE_LAT)));

  assert_enable_latency_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(de_o) |-> ($past(hpos, PIPE_LAT) == '0));

  assert_blank_black_R12: assert property (@(posedge clk) disable iff (rst)
    !de_o |-> (red == 8'h00 && green == 8'h00 && blue == 8'h00));
endmodule

bind hexplane_tilemap hexplane_tilemap_sva #(
  .HW(HW), .VAW(VAW), .RAW(RAW), .TILE_BITS(TILE_BITS)
) u_sva (
  .clk(clk), .rst(rst), .hpos(hpos), .row_in_cell(vpos[CELL_SH-1:0]),
  .vram_addr(vram_addr), .rom_addr(rom_addr), .tile_field(entry_w[TILE_BITS-1:0]),
  .de_o(de_o), .hs_o(hsync_o), .vs_o(vsync_o),
  .red(red_o), .green(green_o), .blue(blue_o)
);

// File: tb/hexplane_tilemap_tb_top.sv
`timescale 1ns/1ps
module hexplane_tilemap_tb_top;
  localparam int COLS = 5, ROWS = 3, TB = 9;
  localparam int HT = 56, HSB = 44, HSE = 47;
  localparam int VT = 30, VSB = 26, VSE = 27;
  localparam int VAW = $clog2(COLS*ROWS*2);
  localparam int RAW = TB + 3;
  localparam int LAT = 9;
  localparam int FRAME = HT * VT;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [VAW-1:0] vram_addr;
  logic [7:0]     vram_data;
  logic [RAW-1:0] rom_addr;
  logic [47:0]    plane_data;
  logic [7:0]     red_o, green_o, blue_o;
  logic           hsync_o, vsync_o, de_o;

  int  vectors = 0;
  int  miscompares = 0;
  bit  done = 0;
  int  seed = 0;
  logic [7:0] vmem [2**VAW];

  always #2.5 clk = ~clk;

  hexplane_tilemap #(
    .COLS(COLS), .ROWS(ROWS), .TILE_BITS(TB), .H_TOTAL(HT), .HS_BEGIN(HSB),
    .HS_END(HSE), .V_TOTAL(VT), .VS_BEGIN(VSB), .VS_END(VSE)
  ) dut_i (
    .clk(clk), .rst(rst), .vram_addr(vram_addr), .vram_data(vram_data),
    .rom_addr(rom_addr), .plane_data(plane_data), .red_o(red_o), .green_o(green_o),
    .blue_o(blue_o), .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o)
  );

  function automatic int rom_byte(input int k, input int a, input int s);
    return ((a * 29 + k * 53 + s * 17) ^ (a >> 4) ^ (k << 5)) & 255;
  endfunction

  always_ff @(posedge clk) vram_data <= vmem[vram_addr];
  always_ff @(posedge clk)
    for (int k = 0; k < 6; k++) plane_data[k*8 +: 8] <= 8'(rom_byte(k, int'(rom_addr), seed));

  task automatic check_cycle(input int n);
    int e_de, e_hs, e_vs, e_r, e_g, e_b;
    int m, x, y, ent, tile, a;
    int pb[6];
    int c[6];
    bit bad;
    e_de = 0; e_hs = 0; e_vs = 0; e_r = 0; e_g = 0; e_b = 0;
    if (n >= LAT) begin
      m = n - LAT;
      x = m % HT;
      y = (m / HT) % VT;
      e_de = (x < COLS*8 && y < ROWS*8) ? 1 : 0;
      e_hs = (x >= HSB && x <= HSE) ? 1 : 0;
      e_vs = (y >= VSB && y <= VSE) ? 1 : 0;
      if (e_de != 0) begin
        ent  = 2 * ((y / 8) * COLS + x / 8);
        tile = ((int'(vmem[ent]) << 8) | int'(vmem[ent+1])) % 512;
        a    = tile * 8 + y % 8;
        for (int k = 0; k < 6; k++) pb[k] = (rom_byte(k, a, seed) >> (7 - x % 8)) & 1;
        c[5] = pb[3]; c[4] = pb[0]; c[3] = pb[4]; c[2] = pb[1]; c[1] = pb[5]; c[0] = pb[2];
        e_b = 79 * c[0] + 168 * c[1];
        e_g = 33 * c[1] + 71 * c[2] + 151 * c[3];
        e_r = 33 * c[3] + 71 * c[4] + 151 * c[5];
      end
    end
    vectors++;
    bad = 0;
    if (n < LAT && (int'(de_o) | int'(hsync_o) | int'(vsync_o) | int'(red_o) | int'(green_o) | int'(blue_o)) != 0) begin
      $display("FAIL R1 reset state cycle %0d: actual de=%0d hs=%0d vs=%0d rgb=%0d/%0d/%0d expected all 0",
               n, de_o, hsync_o, vsync_o, red_o, green_o, blue_o);
      bad = 1;
    end
    if (int'(de_o) != e_de) begin
      $display("FAIL R2 active window cycle %0d: actual de=%0d expected %0d", n, de_o, e_de); bad = 1;
    end
    if (int'(hsync_o) != e_hs) begin
      $display("FAIL R9 line sync cycle %0d: actual %0d expected %0d", n, hsync_o, e_hs); bad = 1;
    end
    if (int'(vsync_o) != e_vs) begin
      $display("FAIL R10 frame sync cycle %0d: actual %0d expected %0d", n, vsync_o, e_vs); bad = 1;
    end
    if (e_de == 0 && (int'(red_o) | int'(green_o) | int'(blue_o)) != 0) begin
      $display("FAIL R12 blank black cycle %0d: actual rgb=%0d/%0d/%0d expected 0/0/0", n, red_o, green_o, blue_o);
      bad = 1;
    end else if (e_de != 0) begin
      // pixel value depends on fetch R3 R4, plane addressing R5, bit order R6, latency R11
      if (int'(blue_o) != e_b) begin
        $display("FAIL R7 blue cycle %0d (via R3 R4 R5 R6 R11): actual %0d expected %0d", n, blue_o, e_b); bad = 1;
      end
      if (int'(green_o) != e_g || int'(red_o) != e_r) begin
        $display("FAIL R8 red/green cycle %0d (via R3 R4 R5 R6 R11): actual %0d/%0d expected %0d/%0d",
                 n, red_o, green_o, e_r, e_g);
        bad = 1;
      end
    end
    if (bad) miscompares++;
  endtask

  task automatic run_phase(input int ph, input int s, input int ncyc);
    @(negedge clk);
    rst = 1'b1;
    seed = s;
    for (int i = 0; i < 2**(VAW-1); i++) begin
      case (ph)
        0: begin vmem[2*i] = 8'((i * 53) ^ 8'hA4); vmem[2*i+1] = 8'(i * 37 + 11); end
        1: begin vmem[2*i] = 8'hFF;                vmem[2*i+1] = 8'(8'hF0 + i);   end
        default: begin vmem[2*i] = (i % 2 == 1) ? 8'h01 : 8'hFE; vmem[2*i+1] = 8'(i * 19); end
      endcase
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int n = 0; n < ncyc; n++) begin
      check_cycle(n);
      @(negedge clk);
    end
  endtask

  initial begin
    run_phase(0, 3, 2 * FRAME + 20);   // R3 R4: varied entries with upper garbage bits
    run_phase(1, 7, 2 * FRAME + 20);   // R4: tiles near the top of the 9-bit range
    run_phase(2, 11, 2 * FRAME + 20);  // R4 R5 R6: bit 8 toggling per cell
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL R11 watchdog: actual run still busy, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule